// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block produces the status word and the ready/busy signal that a NOR-style flash device shows while an internal program or erase runs. A command decoder outside the block issues a one-cycle start with the operation type, the target sector, the byte to be programmed, the byte currently stored at the target and a protection flag. While the operation runs, every read returns a status word instead of array contents. Bit 7 is the polling bit. Bit 6 flips on each read. Bit 5 reports a failure when the pulse limit is exceeded.

A down-to-earth counter stands in for the internal algorithm timing. The program time, the erase time, the protected-sector busy time and the pulse-count limit are all parameters. A program that tries to turn a 0 into a 1 can never verify, so it runs into the pulse limit. A failed operation holds the device in status mode until a reset command arrives. The successful end of a program or an erase is signalled by a one-cycle pulse, which the surrounding array logic uses to commit the write or clear the sector. The ready/busy line is an open-drain enable, meant to be wired with a pull-up.

Top module: `flash_status_rpt`

## Requirements
- R1: After reset the block is in read mode: `rb_oe` is 0 and `dq_out` equals `array_data`.
- R2: A start accepted in read mode sets `rb_oe` from the next cycle onwards. A successful program holds it for exactly PGM_CYC cycles and a successful erase for exactly ERS_CYC cycles. `rb_oe` never rises without a start.
- R3: While `rb_oe` is 1, `dq_out[6]` inverts after every cycle with `rd_strobe` high and holds otherwise. The first read after an accepted start shows 0. In read mode, reads return `array_data`.
- R4: During a program, `dq_out[7]` reads the complement of bit 7 of `prog_data`. On successful completion `wr_commit` pulses for one cycle, in the first cycle with `rb_oe` back at 0.
- R5: During an erase, `dq_out[7]` reads 0 when `rd_sect` equals the erased sector and reads `array_data[7]` otherwise. On completion `sect_clear` pulses for one cycle. `wr_commit` and `sect_clear` are never high together.
- R6: A program with `sect_protected` set keeps `rb_oe` high and bit 6 toggling for exactly PROT_CYC cycles. It then returns to read mode with no `wr_commit`.
- R7: An operation whose duration exceeds PULSE_LIM enters failure after PULSE_LIM busy cycles. In failure `dq_out[5]` is 1, `rb_oe` stays 1 and no completion pulse is issued.
- R8: A program in which `prog_data` has a 1 where `stored_data` has a 0 never completes. It enters failure after PULSE_LIM cycles.
- R9: Failure persists until `reset_cmd`, which returns the block to read mode on the next cycle. `reset_cmd` outside failure is ignored.
- R10: A start while `rb_oe` is 1 is ignored.
- R11: While `rb_oe` is 1, `dq_out[4:0]` is 0. Bit 5 is 0 unless the block is in failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start at the final write strobe of a command |
| op_erase | input | 1 | 1 selects erase, 0 selects program |
| start_sect | input | SECT_W | Target sector of the operation |
| prog_data | input | DATA_W | Byte to be programmed |
| stored_data | input | DATA_W | Byte currently held at the program target |
| sect_protected | input | 1 | Target sector is protected against programming |
| rd_strobe | input | 1 | One cycle per read access |
| rd_sect | input | SECT_W | Sector of the read address |
| array_data | input | DATA_W | Array contents at the read address |
| reset_cmd | input | 1 | Reset command leaving the failure state |
| dq_out | output | DATA_W | Read data or status word |
| rb_oe | output | 1 | Open-drain enable pulling ready/busy low |
| wr_commit | output | 1 | One-cycle pulse when a program succeeds |
| sect_clear | output | 1 | One-cycle pulse when an erase succeeds |

## Verification
Some rules are checked by the assertions on every cycle. They cover the bit-6 flip or hold after each cycle with or without a read, the zero low bits of the status word, and that busy only ever begins with a start. They also check that failure persists until the reset command and then ends at once, that completion pulses are exclusive and come as busy ends, and a bound on busy length outside failure. Other behaviour depends on the data and only the bench scenarios can show it. This covers the exact busy length of each operation kind, the complemented polling bit, the sector dependence during erase, and the missing commit after a protected or failed program. It also covers the array contents seen after each operation and the silent dropping of a second start.

// File: rtl/flash_status_pkg.sv
`timescale 1ns/100ps
package flash_status_pkg;

   typedef enum logic [2:0] {
      PH_READ,
      PH_PGM,
      PH_ERS,
      PH_PROT,
      PH_FAIL
   } fs_phase_e;

   localparam int unsigned POLL_BIT = 7;
   localparam int unsigned TOGL_BIT = 6;
   localparam int unsigned FAIL_BIT = 5;

endpackage

// File: rtl/fs_sequencer.sv
`timescale 1ns/100ps
module fs_sequencer
   import flash_status_pkg::*;
#(
   parameter int unsigned SECT_W    = 2,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PGM_CYC   = 6,
   parameter int unsigned ERS_CYC   = 20,
   parameter int unsigned PROT_CYC  = 10,
   parameter int unsigned PULSE_LIM = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_erase,
   input  logic [SECT_W-1:0] start_sect,
   input  logic [DATA_W-1:0] prog_data,
   input  logic [DATA_W-1:0] stored_data,
   input  logic              sect_protected,
   input  logic              reset_cmd,
   output fs_phase_e         phase,
   output logic              is_erase,
   output logic              poll_src,
   output logic [SECT_W-1:0] sect_q,
   output logic              wr_commit,
   output logic              sect_clear
);

   localparam int unsigned MAX_A   = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
   localparam int unsigned MAX_B   = (PROT_CYC > PULSE_LIM) ? PROT_CYC : PULSE_LIM;
   localparam int unsigned MAX_DUR = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned CNT_W   = $clog2(MAX_DUR + 1);

   localparam logic [CNT_W-1:0] PGM_LAST  = CNT_W'(PGM_CYC - 1);
   localparam logic [CNT_W-1:0] ERS_LAST  = CNT_W'(ERS_CYC - 1);
   localparam logic [CNT_W-1:0] PROT_LAST = CNT_W'(PROT_CYC - 1);
   localparam logic [CNT_W-1:0] LIM_LAST  = CNT_W'(PULSE_LIM - 1);

   logic [CNT_W-1:0] cnt;
   logic             unverifiable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase        <= PH_READ;
         cnt          <= '0;
         is_erase     <= 1'b0;
         poll_src     <= 1'b0;
         sect_q       <= '0;
         unverifiable <= 1'b0;
         wr_commit    <= 1'b0;
         sect_clear   <= 1'b0;
      end else begin
         wr_commit  <= 1'b0;
         sect_clear <= 1'b0;
         unique case (phase)
            PH_READ: begin
               if (start) begin
                  cnt          <= '0;
                  is_erase     <= op_erase;
                  poll_src     <= prog_data[POLL_BIT];
                  sect_q       <= start_sect;
                  unverifiable <= |(prog_data & ~stored_data);
                  if (op_erase)            phase <= PH_ERS;
                  else if (sect_protected) phase <= PH_PROT;
                  else                     phase <= PH_PGM;
               end
            end
            PH_PGM: begin
               cnt <= cnt + 1'b1;
               if (cnt == PGM_LAST && !unverifiable) begin
                  phase     <= PH_READ;
                  wr_commit <= 1'b1;
               end else if (cnt == LIM_LAST) begin
                  phase <= PH_FAIL;
               end
            end
            PH_ERS: begin
               cnt <= cnt + 1'b1;
               if (cnt == ERS_LAST) begin
                  phase      <= PH_READ;
                  sect_clear <= 1'b1;
               end else if (cnt == LIM_LAST) begin
                  phase <= PH_FAIL;
               end
            end
            PH_PROT: begin
               cnt <= cnt + 1'b1;
               if (cnt == PROT_LAST) phase <= PH_READ;
            end
            PH_FAIL: begin
               if (reset_cmd) phase <= PH_READ;
            end
            default: phase <= PH_READ;
         endcase
      end
   end

endmodule

// File: rtl/fs_toggle.sv
`timescale 1ns/100ps
module fs_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic active,
   input  logic rd_strobe,
   output logic tog
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  tog <= 1'b0;
      else if (clr)                tog <= 1'b0;
      else if (active && rd_strobe) tog <= ~tog;
   end

endmodule

// File: rtl/fs_word_mux.sv
`timescale 1ns/100ps
module fs_word_mux
   import flash_status_pkg::*;
#(
   parameter int unsigned SECT_W = 2,
   parameter int unsigned DATA_W = 8
) (
   input  fs_phase_e         phase,
   input  logic              is_erase,
   input  logic              poll_src,
   input  logic [SECT_W-1:0] sect_q,
   input  logic [SECT_W-1:0] rd_sect,
   input  logic [DATA_W-1:0] array_data,
   input  logic              tog,
   output logic [DATA_W-1:0] dq_out
);

   logic [DATA_W-1:0] status_word;
   logic              poll_bit;

   always_comb begin
      if (is_erase) poll_bit = (rd_sect == sect_q) ? 1'b0 : array_data[POLL_BIT];
      else          poll_bit = ~poll_src;
   end

   always_comb begin
      status_word           = '0;
      status_word[POLL_BIT] = poll_bit;
      status_word[TOGL_BIT] = tog;
      status_word[FAIL_BIT] = (phase == PH_FAIL);
   end

   assign dq_out = (phase == PH_READ) ? array_data : status_word;

endmodule

// File: rtl/flash_status_rpt.sv
`timescale 1ns/100ps
module flash_status_rpt
   import flash_status_pkg::*;
#(
   parameter int unsigned SECT_W    = 2,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PGM_CYC   = 6,
   parameter int unsigned ERS_CYC   = 20,
   parameter int unsigned PROT_CYC  = 10,
   parameter int unsigned PULSE_LIM = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_erase,
   input  logic [SECT_W-1:0] start_sect,
   input  logic [DATA_W-1:0] prog_data,
   input  logic [DATA_W-1:0] stored_data,
   input  logic              sect_protected,
   input  logic              rd_strobe,
   input  logic [SECT_W-1:0] rd_sect,
   input  logic [DATA_W-1:0] array_data,
   input  logic              reset_cmd,
   output logic [DATA_W-1:0] dq_out,
   output logic              rb_oe,
   output logic              wr_commit,
   output logic              sect_clear
);

   if (DATA_W < 8) begin : g_bad_data_w
      $error("flash_status_rpt: DATA_W must be at least 8");
   end
   if (SECT_W < 1) begin : g_bad_sect_w
      $error("flash_status_rpt: SECT_W must be at least 1");
   end
   if (PGM_CYC < 1 || ERS_CYC < 1 || PROT_CYC < 1 || PULSE_LIM < 1) begin : g_bad_cyc
      $error("flash_status_rpt: cycle counts must be at least 1");
   end

   fs_phase_e         phase;
   logic              is_erase;
   logic              poll_src;
   logic [SECT_W-1:0] sect_q;
   logic              tog;
   logic              accept;

   assign accept = start && (phase == PH_READ);
   assign rb_oe  = (phase != PH_READ);

   fs_sequencer #(
      .SECT_W(SECT_W), .DATA_W(DATA_W), .PGM_CYC(PGM_CYC),
      .ERS_CYC(ERS_CYC), .PROT_CYC(PROT_CYC), .PULSE_LIM(PULSE_LIM)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
      .start_sect(start_sect), .prog_data(prog_data), .stored_data(stored_data),
      .sect_protected(sect_protected), .reset_cmd(reset_cmd),
      .phase(phase), .is_erase(is_erase), .poll_src(poll_src), .sect_q(sect_q),
      .wr_commit(wr_commit), .sect_clear(sect_clear)
   );

   fs_toggle u_tog (
      .clk(clk), .rst_n(rst_n), .clr(accept), .active(rb_oe),
      .rd_strobe(rd_strobe), .tog(tog)
   );

   fs_word_mux #(.SECT_W(SECT_W), .DATA_W(DATA_W)) u_mux (
      .phase(phase), .is_erase(is_erase), .poll_src(poll_src), .sect_q(sect_q),
      .rd_sect(rd_sect), .array_data(array_data), .tog(tog), .dq_out(dq_out)
   );

endmodule

// File: rtl/flash_status_rpt_chk.sv
`timescale 1ns/100ps
module flash_status_rpt_chk #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PGM_CYC   = 6,
   parameter int unsigned ERS_CYC   = 20,
   parameter int unsigned PROT_CYC  = 10,
   parameter int unsigned PULSE_LIM = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              rd_strobe,
   input logic              reset_cmd,
   input logic [DATA_W-1:0] dq_out,
   input logic              rb_oe,
   input logic              wr_commit,
   input logic              sect_clear
);

   localparam int unsigned MAX_A   = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
   localparam int unsigned MAX_B   = (PROT_CYC > PULSE_LIM) ? PROT_CYC : PULSE_LIM;
   localparam int unsigned MAX_RUN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned RUN_W   = $clog2(MAX_RUN + 1);
   localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(MAX_RUN);

   logic [RUN_W-1:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               busy_run <= '0;
      else if (!rb_oe)          busy_run <= '0;
      else if (busy_run != RUN_CAP) busy_run <= busy_run + 1'b1;
   end

   // R2: busy begins only through a start
   a_r2_rise_by_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rb_oe) |-> $past(start));

   // R2: busy outside failure never outlasts the longest operation
   a_r2_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_oe && !dq_out[5]) |-> (busy_run < RUN_CAP));

   // R3: a read in status mode inverts bit 6
   a_r3_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_oe && rd_strobe) ##1 rb_oe |-> (dq_out[6] != $past(dq_out[6])));

   // R3: no read, no change of bit 6
   a_r3_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_oe && !rd_strobe) ##1 rb_oe |-> $stable(dq_out[6]));

   // R4: program commit marks the end of busy
   a_r4_commit_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> (!rb_oe && $past(rb_oe)));

   // R5: erase completion marks the end of busy; pulses exclusive
   a_r5_clear_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      sect_clear |-> (!rb_oe && $past(rb_oe)));

   a_r5_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_commit, sect_clear}));

   // R7 / R9: failure holds until the reset command
   a_r7_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_oe && dq_out[5] && !reset_cmd) |=> (rb_oe && dq_out[5]));

   // R9: reset command leaves failure at once
   a_r9_reset_exits: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_oe && dq_out[5] && reset_cmd) |=> !rb_oe);

   // R11: low status bits are zero
   a_r11_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rb_oe |-> (dq_out[4:0] == 5'd0));

endmodule

bind flash_status_rpt flash_status_rpt_chk #(
   .DATA_W(DATA_W), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC),
   .PROT_CYC(PROT_CYC), .PULSE_LIM(PULSE_LIM)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .rd_strobe(rd_strobe),
   .reset_cmd(reset_cmd), .dq_out(dq_out), .rb_oe(rb_oe),
   .wr_commit(wr_commit), .sect_clear(sect_clear)
);

// File: tb/test_flash_status_rpt.sv
`timescale 1ns/100ps
module test_flash_status_rpt;

   localparam int PGM_CYC   = 6;
   localparam int ERS_CYC   = 20;
   localparam int PROT_CYC  = 10;
   localparam int PULSE_LIM = 40;
   localparam int LIM2      = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, start2 = 1'b0;
   logic       op_erase = 1'b0;
   logic       sect_protected = 1'b0;
   logic       rd_strobe = 1'b0;
   logic       reset_cmd = 1'b0, reset2 = 1'b0;
   logic [7:0] st_addr = 8'h00, rd_addr = 8'h00, prog_data = 8'h00;
   logic [7:0] mem [256];
   logic [7:0] stored_data, array_data;
   logic [7:0] dq, dq2;
   logic       rb_oe, rb_oe2, wr_commit, wr_commit2, sect_clear, sect_clear2;
   int         n_commit = 0, n_clear = 0, n_clear2 = 0;
   int         n_chk = 0, n_err = 0;

   always #2.5 clk = ~clk;

   // open-drain line resolved against a pull-up
   wire rb_line  = rb_oe  ? 1'b0 : 1'b1;
   wire rb_line2 = rb_oe2 ? 1'b0 : 1'b1;

   assign stored_data = mem[st_addr];
   assign array_data  = mem[rd_addr];

   // array model of the surrounding device
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      end else begin
         if (wr_commit) mem[st_addr] <= mem[st_addr] & prog_data;
         if (sect_clear)
            for (int i = 0; i < 256; i++)
               if (8'(i) >> 6 == {6'd0, st_addr[7:6]}) mem[i] <= 8'hFF;
         if (wr_commit)   n_commit <= n_commit + 1;
         if (sect_clear)  n_clear  <= n_clear + 1;
         if (sect_clear2) n_clear2 <= n_clear2 + 1;
      end
   end

   flash_status_rpt #(
      .SECT_W(2), .DATA_W(8), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC),
      .PROT_CYC(PROT_CYC), .PULSE_LIM(PULSE_LIM)
   ) i_flash_status_rpt (
      .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
      .start_sect(st_addr[7:6]), .prog_data(prog_data), .stored_data(stored_data),
      .sect_protected(sect_protected), .rd_strobe(rd_strobe), .rd_sect(rd_addr[7:6]),
      .array_data(array_data), .reset_cmd(reset_cmd), .dq_out(dq), .rb_oe(rb_oe),
      .wr_commit(wr_commit), .sect_clear(sect_clear)
   );

   flash_status_rpt #(
      .SECT_W(2), .DATA_W(8), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC),
      .PROT_CYC(PROT_CYC), .PULSE_LIM(LIM2)
   ) i_flash_status_rpt_tmo (
      .clk(clk), .rst_n(rst_n), .start(start2), .op_erase(op_erase),
      .start_sect(st_addr[7:6]), .prog_data(prog_data), .stored_data(stored_data),
      .sect_protected(sect_protected), .rd_strobe(rd_strobe), .rd_sect(rd_addr[7:6]),
      .array_data(array_data), .reset_cmd(reset2), .dq_out(dq2), .rb_oe(rb_oe2),
      .wr_commit(wr_commit2), .sect_clear(sect_clear2)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic launch(input logic ers, input logic [7:0] a, input logic [7:0] d,
                         input logic prot, input logic second);
      st_addr = a; prog_data = d; op_erase = ers; sect_protected = prot;
      if (second) start2 = 1'b1; else start = 1'b1;
      @(negedge clk);
      start = 1'b0; start2 = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      rd_addr = a; rd_strobe = 1'b1;
      #1 v = dq;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [7:0] v);
      rd_addr = a;
      #1 v = dq;
   endtask

   task automatic idle_count(output int n);
      n = 0;
      #1;
      while (rb_line == 1'b0 && n < 1000) begin
         @(negedge clk);
         #1;
         n++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [7:0] v, v2, old, d, a, other;
      int n, c0;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1: reset state, every address
      chk("R1 rb", {31'd0, rb_line}, 32'd1);
      for (int i = 0; i < 256; i++) begin
         peek(8'(i), v);
         chk("R1 read", {24'd0, v}, {24'd0, 8'(i) ^ 8'h5A});
      end

      // R2 R3 R4 R11: programs with varied data
      for (int k = 0; k < 12; k++) begin
         a   = 8'((k * 37 + 5) & 8'hFF);
         old = mem[a];
         d   = old & ~(8'h01 << (k % 8));
         c0  = n_commit;
         launch(1'b0, a, d, 1'b0, 1'b0);
         rd(a ^ 8'h01, v);
         chk("R4 poll", {31'd0, v[7]}, {31'd0, ~d[7]});
         chk("R3 first", {31'd0, v[6]}, 32'd0);
         chk("R11 low", {26'd0, v[5:0]}, 32'd0);
         rd(a ^ 8'h40, v2);
         chk("R3 second", {31'd0, v2[6]}, 32'd1);
         idle_count(n);
         chk("R2 pgm len", n + 2, PGM_CYC);
         step();
         chk("R4 commit", n_commit - c0, 1);
         peek(a, v);
         chk("R4 data", {24'd0, v}, {24'd0, old & d});
      end

      // R5: erase each sector
      for (int s = 0; s < 4; s++) begin
         a     = {2'(s), 6'h11};
         other = {2'(s + 1), 6'h03};
         old   = mem[other];
         c0    = n_clear;
         launch(1'b1, a, 8'h00, 1'b0, 1'b0);
         rd({2'(s), 6'h2A}, v);
         chk("R5 in-sect poll", {31'd0, v[7]}, 32'd0);
         rd(other, v2);
         chk("R5 out-sect poll", {31'd0, v2[7]}, {31'd0, old[7]});
         chk("R3 erase toggle", {31'd0, v2[6]}, 32'd1);
         idle_count(n);
         chk("R2 ers len", n + 2, ERS_CYC);
         step();
         chk("R5 clear", n_clear - c0, 1);
         peek({2'(s), 6'h3F}, v);
         chk("R5 erased", {24'd0, v}, 32'hFF);
         peek(other, v);
         chk("R5 other sect", {24'd0, v}, {24'd0, old});
      end

      // R6: protected program
      c0 = n_commit;
      launch(1'b0, 8'h90, 8'h00, 1'b1, 1'b0);
      for (int j = 0; j < 4; j++) begin
         rd(8'h90, v);
         chk("R6 toggle", {31'd0, v[6]}, 32'(j % 2));
         chk("R6 poll", {31'd0, v[7]}, 32'd1);
      end
      idle_count(n);
      chk("R6 len", n + 4, PROT_CYC);
      step();
      chk("R6 no commit", n_commit - c0, 0);
      peek(8'h90, v);
      chk("R6 unchanged", {24'd0, v}, 32'hFF);
      sect_protected = 1'b0;

      // R10 and R9 ignore: second start and reset command while busy
      c0 = n_commit;
      launch(1'b0, 8'h95, 8'h3C, 1'b0, 1'b0);
      step();
      launch(1'b0, 8'h96, 8'h00, 1'b0, 1'b0);
      st_addr = 8'h95; prog_data = 8'h3C;
      reset_cmd = 1'b1;
      step();
      reset_cmd = 1'b0;
      idle_count(n);
      chk("R10 len", n + 3, PGM_CYC);
      step();
      chk("R10 one commit", n_commit - c0, 1);
      peek(8'h95, v);
      chk("R10 target", {24'd0, v}, 32'h3C);
      peek(8'h96, v);
      chk("R10 second ignored", {24'd0, v}, 32'hFF);

      // R8: program of a 1 over a 0
      c0 = n_commit;
      launch(1'b0, 8'h95, 8'hC3, 1'b0, 1'b0);
      repeat (PULSE_LIM - 1) step();
      peek(8'h95, v);
      chk("R8 before limit", {31'd0, v[5]}, 32'd0);
      chk("R8 busy", {31'd0, rb_line}, 32'd0);
      step();
      peek(8'h95, v);
      chk("R8 fail bit", {31'd0, v[5]}, 32'd1);
      rd(8'h95, v);
      rd(8'h95, v2);
      chk("R3 fail toggle", {31'd0, v[6] ^ v2[6]}, 32'd1);
      chk("R11 fail low", {27'd0, v2[4:0]}, 32'd0);
      repeat (5) step();
      chk("R9 holds", {31'd0, rb_line}, 32'd0);
      reset_cmd = 1'b1;
      step();
      reset_cmd = 1'b0;
      #1;
      chk("R9 exit", {31'd0, rb_line}, 32'd1);
      peek(8'h95, v);
      chk("R9 read mode", {24'd0, v}, 32'h3C);
      chk("R8 no commit", n_commit - c0, 0);

      // R7: erase longer than the pulse limit on the second instance
      c0 = n_clear2;
      launch(1'b1, 8'hC4, 8'h00, 1'b0, 1'b1);
      repeat (LIM2 - 1) step();
      #1;
      chk("R7 before limit", {31'd0, dq2[5]}, 32'd0);
      step();
      #1;
      chk("R7 fail bit", {31'd0, dq2[5]}, 32'd1);
      chk("R7 busy", {31'd0, rb_line2}, 32'd0);
      repeat (ERS_CYC) step();
      chk("R7 no clear", n_clear2 - c0, 0);
      chk("R7 still failed", {31'd0, rb_line2}, 32'd0);
      reset2 = 1'b1;
      step();
      reset2 = 1'b0;
      #1;
      chk("R9 second exit", {31'd0, rb_line2}, 32'd1);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule